// File: doc/BRIEF.md
# Register-Combining Load/Store Datapath

This block is the 8-bit execution slice that serves the undocumented 6502 operations which either load one operand into several registers at once or store a bitwise AND of registers. The sequencer asserts a start strobe together with an operation class, the current A, X, Y and S values, the operand byte and the high byte of the effective address. Operand fetch, address generation and the bus are handled elsewhere. On the next clock edge the block registers the new register values, a memory write request with its data, and the N/Z flags. Each of these comes with its own write enable, and a single-cycle done pulse marks the result.

The constant that the unstable immediate forms OR into A is a parameter, so that other silicon variants can be modelled. Every data output holds its last written value until a later operation writes it again. Only the enables and done are pulses.

Top module: `regmerge_unit`

## Requirements
- R1: While rst_ni is low, every output is 0.
- R2: done_o is 1 in exactly the cycle after a cycle with start_i high. All write enables are 0 whenever done_o is 0. Each data output (a_o, x_o, s_o, mem_wd_o, n_o/z_o) changes only in a cycle where its own enable is 1, and otherwise keeps its last value.
- R3: Class 0 (LAX) loads the operand into A and X (a_we_o, x_we_o) and writes the flags.
- R4: Class 1 (SAX) requests a memory write of A AND X and writes no register and no flag.
- R5: Class 2 (ANE) writes A = (A OR MAGIC) AND X AND operand, where MAGIC defaults to 0xEE, and writes the flags.
- R6: Class 3 (LXA) writes A = X = (A OR MAGIC) AND operand and writes the flags.
- R7: Class 4 (SHY), class 5 (SHX) and class 6 (SHA) store Y, X and A AND X respectively, each ANDed with (address high byte + 1) modulo 256. They write no register and no flag.
- R8: Class 7 (TAS) stores A AND X AND (address high byte + 1), loads S with A AND X, and writes no flag.
- R9: Class 8 (LAS) writes A = X = S = operand AND S and writes the flags.
- R10: Class codes 9 to 15 produce done_o but raise no write enable.
- R11: When nz_we_o is 1, n_o equals bit 7 of the loaded value and z_o is 1 exactly when that value is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch an operation this cycle |
| cls_i | input | 4 | Operation class code |
| a_i | input | 8 | Current A |
| x_i | input | 8 | Current X |
| y_i | input | 8 | Current Y |
| s_i | input | 8 | Current S |
| opnd_i | input | 8 | Operand byte (memory or immediate) |
| ea_hi_i | input | 8 | Effective address high byte |
| a_o | output | 8 | New A |
| a_we_o | output | 1 | A write enable |
| x_o | output | 8 | New X |
| x_we_o | output | 1 | X write enable |
| s_o | output | 8 | New S |
| s_we_o | output | 1 | S write enable |
| mem_wd_o | output | 8 | Memory write data |
| mem_we_o | output | 1 | Memory write request |
| n_o | output | 1 | New N flag |
| z_o | output | 1 | New Z flag |
| nz_we_o | output | 1 | Flag write enable |
| done_o | output | 1 | Result valid pulse |

## Verification
A wrong decode of the class shows up as a spurious or missing enable in the one cycle after start. Because the data outputs hold between writes, a stray write also changes a held value that the following idle cycles expose. A wrong term in the AND/OR network, or a high-byte increment that does not wrap, shows as a data mismatch in that same cycle. The reference model compares every output on every clock, so any fault is reported no later than the cycle after the operation that triggers it.

// File: rtl/regmerge_pkg.sv
package regmerge_pkg;
  localparam int CLS_W = 4;

  localparam logic [CLS_W-1:0] CLS_LAX = 4'd0;
  localparam logic [CLS_W-1:0] CLS_SAX = 4'd1;
  localparam logic [CLS_W-1:0] CLS_ANE = 4'd2;
  localparam logic [CLS_W-1:0] CLS_LXA = 4'd3;
  localparam logic [CLS_W-1:0] CLS_SHY = 4'd4;
  localparam logic [CLS_W-1:0] CLS_SHX = 4'd5;
  localparam logic [CLS_W-1:0] CLS_SHA = 4'd6;
  localparam logic [CLS_W-1:0] CLS_TAS = 4'd7;
  localparam logic [CLS_W-1:0] CLS_LAS = 4'd8;

  typedef enum logic [1:0] {LD_OPND, LD_ANE, LD_LXA, LD_LAS} ld_sel_e;
  typedef enum logic [1:0] {ST_AX, ST_X, ST_Y} st_sel_e;
  typedef enum logic {S_FROM_AX, S_FROM_LD} s_sel_e;

  typedef struct packed {
    logic    a_we;
    logic    x_we;
    logic    s_we;
    logic    mem_we;
    logic    nz_we;
    ld_sel_e ld_sel;
    st_sel_e st_sel;
    logic    st_hi;
    s_sel_e  s_sel;
  } ctl_t;
endpackage

// File: rtl/regmerge_decode.sv
module regmerge_decode
  import regmerge_pkg::*;
(
  input  logic [CLS_W-1:0] cls_i,
  output ctl_t             ctl_o
);
  always_comb begin
    ctl_o = '{a_we: 1'b0, x_we: 1'b0, s_we: 1'b0, mem_we: 1'b0, nz_we: 1'b0,
              ld_sel: LD_OPND, st_sel: ST_AX, st_hi: 1'b0, s_sel: S_FROM_AX};
    case (cls_i)
      CLS_LAX: begin
        ctl_o.a_we = 1'b1; ctl_o.x_we = 1'b1; ctl_o.nz_we = 1'b1;
      end
      CLS_SAX: ctl_o.mem_we = 1'b1;
      CLS_ANE: begin
        ctl_o.a_we = 1'b1; ctl_o.nz_we = 1'b1; ctl_o.ld_sel = LD_ANE;
      end
      CLS_LXA: begin
        ctl_o.a_we = 1'b1; ctl_o.x_we = 1'b1; ctl_o.nz_we = 1'b1;
        ctl_o.ld_sel = LD_LXA;
      end
      CLS_SHY: begin
        ctl_o.mem_we = 1'b1; ctl_o.st_sel = ST_Y; ctl_o.st_hi = 1'b1;
      end
      CLS_SHX: begin
        ctl_o.mem_we = 1'b1; ctl_o.st_sel = ST_X; ctl_o.st_hi = 1'b1;
      end
      CLS_SHA: begin
        ctl_o.mem_we = 1'b1; ctl_o.st_hi = 1'b1;
      end
      CLS_TAS: begin
        ctl_o.mem_we = 1'b1; ctl_o.st_hi = 1'b1; ctl_o.s_we = 1'b1;
      end
      CLS_LAS: begin
        ctl_o.a_we = 1'b1; ctl_o.x_we = 1'b1; ctl_o.s_we = 1'b1;
        ctl_o.nz_we = 1'b1; ctl_o.ld_sel = LD_LAS; ctl_o.s_sel = S_FROM_LD;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/regmerge_alu.sv
module regmerge_alu
  import regmerge_pkg::*;
#(
  parameter int         W     = 8,
  parameter logic [W-1:0] MAGIC = 8'hEE
) (
  input  ctl_t         ctl_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] s_i,
  input  logic [W-1:0] opnd_i,
  input  logic [W-1:0] ea_hi_i,
  output logic [W-1:0] ld_o,
  output logic [W-1:0] st_o,
  output logic [W-1:0] s_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] hi_inc;
  logic [W-1:0] ax;
  logic [W-1:0] a_mag;
  logic [W-1:0] st_base;

  assign hi_inc = ea_hi_i + ONE;  // wraps modulo 2^W
  assign ax     = a_i & x_i;
  assign a_mag  = a_i | MAGIC;

  always_comb begin
    case (ctl_i.ld_sel)
      LD_ANE:  ld_o = a_mag & x_i & opnd_i;
      LD_LXA:  ld_o = a_mag & opnd_i;
      LD_LAS:  ld_o = opnd_i & s_i;
      default: ld_o = opnd_i;
    endcase
  end

  always_comb begin
    case (ctl_i.st_sel)
      ST_X:    st_base = x_i;
      ST_Y:    st_base = y_i;
      default: st_base = ax;
    endcase
  end

  assign st_o = ctl_i.st_hi ? (st_base & hi_inc) : st_base;
  assign s_o  = (ctl_i.s_sel == S_FROM_LD) ? ld_o : ax;
endmodule

// File: rtl/regmerge_outreg.sv
module regmerge_outreg
  import regmerge_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         fire_i,
  input  ctl_t         ctl_i,
  input  logic [W-1:0] ld_i,
  input  logic [W-1:0] st_i,
  input  logic [W-1:0] s_i,
  output logic [W-1:0] a_o,
  output logic         a_we_o,
  output logic [W-1:0] x_o,
  output logic         x_we_o,
  output logic [W-1:0] s_o,
  output logic         s_we_o,
  output logic [W-1:0] mem_wd_o,
  output logic         mem_we_o,
  output logic         n_o,
  output logic         z_o,
  output logic         nz_we_o,
  output logic         done_o
);
  logic wa, wx, ws, wm, wf;

  assign wa = fire_i & ctl_i.a_we;
  assign wx = fire_i & ctl_i.x_we;
  assign ws = fire_i & ctl_i.s_we;
  assign wm = fire_i & ctl_i.mem_we;
  assign wf = fire_i & ctl_i.nz_we;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_we_o <= 1'b0; x_we_o <= 1'b0; s_we_o <= 1'b0;
      mem_we_o <= 1'b0; nz_we_o <= 1'b0; done_o <= 1'b0;
    end else begin
      a_we_o <= wa; x_we_o <= wx; s_we_o <= ws;
      mem_we_o <= wm; nz_we_o <= wf; done_o <= fire_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_o <= '0; x_o <= '0; s_o <= '0; mem_wd_o <= '0;
      n_o <= 1'b0; z_o <= 1'b0;
    end else begin
      if (wa) a_o <= ld_i;
      if (wx) x_o <= ld_i;
      if (ws) s_o <= s_i;
      if (wm) mem_wd_o <= st_i;
      if (wf) begin
        n_o <= ld_i[W-1];
        z_o <= (ld_i == '0);
      end
    end
  end
endmodule

// File: rtl/regmerge_unit.sv
module regmerge_unit
  import regmerge_pkg::*;
#(
  parameter int           W     = 8,
  parameter logic [W-1:0] MAGIC = 8'hEE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CLS_W-1:0] cls_i,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     x_i,
  input  logic [W-1:0]     y_i,
  input  logic [W-1:0]     s_i,
  input  logic [W-1:0]     opnd_i,
  input  logic [W-1:0]     ea_hi_i,
  output logic [W-1:0]     a_o,
  output logic             a_we_o,
  output logic [W-1:0]     x_o,
  output logic             x_we_o,
  output logic [W-1:0]     s_o,
  output logic             s_we_o,
  output logic [W-1:0]     mem_wd_o,
  output logic             mem_we_o,
  output logic             n_o,
  output logic             z_o,
  output logic             nz_we_o,
  output logic             done_o
);
  ctl_t         ctl;
  logic [W-1:0] ld_val, st_val, s_val;

  regmerge_decode u_dec (
    .cls_i (cls_i),
    .ctl_o (ctl)
  );

  regmerge_alu #(.W(W), .MAGIC(MAGIC)) u_alu (
    .ctl_i   (ctl),
    .a_i     (a_i),
    .x_i     (x_i),
    .y_i     (y_i),
    .s_i     (s_i),
    .opnd_i  (opnd_i),
    .ea_hi_i (ea_hi_i),
    .ld_o    (ld_val),
    .st_o    (st_val),
    .s_o     (s_val)
  );

  regmerge_outreg #(.W(W)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fire_i   (start_i),
    .ctl_i    (ctl),
    .ld_i     (ld_val),
    .st_i     (st_val),
    .s_i      (s_val),
    .a_o      (a_o),
    .a_we_o   (a_we_o),
    .x_o      (x_o),
    .x_we_o   (x_we_o),
    .s_o      (s_o),
    .s_we_o   (s_we_o),
    .mem_wd_o (mem_wd_o),
    .mem_we_o (mem_we_o),
    .n_o      (n_o),
    .z_o      (z_o),
    .nz_we_o  (nz_we_o),
    .done_o   (done_o)
  );
endmodule

// File: rtl/regmerge_unit_chk.sv
module regmerge_unit_chk
  import regmerge_pkg::*;
#(
  parameter int W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [CLS_W-1:0] cls_i,
  input logic [W-1:0]     a_i,
  input logic [W-1:0]     x_i,
  input logic [W-1:0]     y_i,
  input logic [W-1:0]     s_i,
  input logic [W-1:0]     opnd_i,
  input logic [W-1:0]     ea_hi_i,
  input logic [W-1:0]     a_o,
  input logic             a_we_o,
  input logic [W-1:0]     x_o,
  input logic             x_we_o,
  input logic [W-1:0]     s_o,
  input logic             s_we_o,
  input logic [W-1:0]     mem_wd_o,
  input logic             mem_we_o,
  input logic             n_o,
  input logic             z_o,
  input logic             nz_we_o,
  input logic             done_o
);
  p_done_follows_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o);

  p_no_we_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> !(a_we_o || x_we_o || s_we_o || mem_we_o || nz_we_o));

  p_a_holds_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !a_we_o |=> (a_we_o || $stable(a_o)));

  p_lax_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && cls_i == CLS_LAX) |=> (a_o == $past(opnd_i) && x_o == $past(opnd_i) && nz_we_o));

  p_sax_store_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && cls_i == CLS_SAX) |=>
      (mem_we_o && mem_wd_o == $past(a_i & x_i) && !nz_we_o && !a_we_o && !x_we_o && !s_we_o));

  p_shy_store_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && cls_i == CLS_SHY) |=>
      (mem_we_o && mem_wd_o == ($past(y_i) & W'($past(ea_hi_i) + 1'b1)) && !nz_we_o));

  p_tas_s_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && cls_i == CLS_TAS) |=> (s_we_o && s_o == $past(a_i & x_i) && !nz_we_o));

  p_las_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && cls_i == CLS_LAS) |=> (s_o == $past(opnd_i & s_i) && a_o == s_o && x_o == s_o));

  p_unused_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && cls_i > CLS_LAS) |=> !(a_we_o || x_we_o || s_we_o || mem_we_o || nz_we_o));

  p_flags_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nz_we_o |-> (n_o == a_o[W-1] && z_o == (a_o == '0)));
endmodule

bind regmerge_unit regmerge_unit_chk #(.W(W)) u_chk (.*);

// File: tb/regmerge_unit_test.sv
`timescale 1ns/1ps
module regmerge_unit_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [3:0] cls_i = '0;
  logic [7:0] a_i = '0, x_i = '0, y_i = '0, s_i = '0, opnd_i = '0, ea_hi_i = '0;
  logic [7:0] a_o, x_o, s_o, mem_wd_o;
  logic       a_we_o, x_we_o, s_we_o, mem_we_o, n_o, z_o, nz_we_o, done_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk_i = ~clk_i;

  regmerge_unit uut (.*);

  // behavioural reference
  logic [7:0] e_a, e_x, e_s, e_wd;
  logic       e_awe, e_xwe, e_swe, e_mwe, e_n, e_z, e_fwe, e_done;
  string      e_tag;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      e_a <= 0; e_x <= 0; e_s <= 0; e_wd <= 0; e_n <= 0; e_z <= 0;
      e_awe <= 0; e_xwe <= 0; e_swe <= 0; e_mwe <= 0; e_fwe <= 0; e_done <= 0;
      e_tag <= "R1";
    end else begin
      logic [7:0] hi1, r;
      bit la, lx, ls, lm, lf;
      logic [7:0] sv, mv;
      hi1 = ea_hi_i + 8'd1;
      la = 0; lx = 0; ls = 0; lm = 0; lf = 0; r = 0; sv = 0; mv = 0;
      e_done <= start_i;
      e_tag <= "R2";
      if (start_i) begin
        case (cls_i)
          0: begin r = opnd_i; la = 1; lx = 1; lf = 1; e_tag <= "R3"; end
          1: begin mv = a_i & x_i; lm = 1; e_tag <= "R4"; end
          2: begin r = (a_i | 8'hEE) & x_i & opnd_i; la = 1; lf = 1; e_tag <= "R5"; end
          3: begin r = (a_i | 8'hEE) & opnd_i; la = 1; lx = 1; lf = 1; e_tag <= "R6"; end
          4: begin mv = y_i & hi1; lm = 1; e_tag <= "R7"; end
          5: begin mv = x_i & hi1; lm = 1; e_tag <= "R7"; end
          6: begin mv = a_i & x_i & hi1; lm = 1; e_tag <= "R7"; end
          7: begin mv = a_i & x_i & hi1; sv = a_i & x_i; lm = 1; ls = 1; e_tag <= "R8"; end
          8: begin r = opnd_i & s_i; sv = r; la = 1; lx = 1; ls = 1; lf = 1; e_tag <= "R9"; end
          default: e_tag <= "R10";
        endcase
      end
      e_awe <= la; e_xwe <= lx; e_swe <= ls; e_mwe <= lm; e_fwe <= lf;
      if (la) e_a <= r;
      if (lx) e_x <= r;
      if (ls) e_s <= sv;
      if (lm) e_wd <= mv;
      if (lf) begin e_n <= r[7]; e_z <= (r == 0); end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk_i) begin
    if (!finished) begin
      logic [43:0] act, exp;
      act = {a_o, x_o, s_o, mem_wd_o, a_we_o, x_we_o, s_we_o, mem_we_o, n_o, z_o, nz_we_o, done_o};
      exp = {e_a, e_x, e_s, e_wd, e_awe, e_xwe, e_swe, e_mwe, e_n, e_z, e_fwe, e_done};
      total++;
      if (act !== exp) begin
        bad++;
        $display("FAIL %s (R11 flags incl.) act=%h exp=%h t=%0t", e_tag, act, exp, $time);
      end
    end
  end

  task automatic op(input logic [3:0] c, input logic [7:0] a, x, y, s, d, hi);
    cls_i = c; a_i = a; x_i = x; y_i = y; s_i = s; opnd_i = d; ea_hi_i = hi;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    a_i = 8'hA5; x_i = 8'h5A; y_i = 8'hC3; s_i = 8'h3C; opnd_i = 8'h77; ea_hi_i = 8'h99;
    @(negedge clk_i);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1;
    total++;
    if ({a_o, x_o, s_o, mem_wd_o, a_we_o, x_we_o, s_we_o, mem_we_o, n_o, z_o, nz_we_o, done_o} !== '0) begin
      bad++;
      $display("FAIL R1 reset outputs not zero");
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R3 / R11: plain, zero, negative
    op(0, 8'h12, 8'h34, 8'h00, 8'h00, 8'h55, 8'h00);
    op(0, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00);
    op(0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h80, 8'h00);
    // R4
    op(1, 8'hF0, 8'h3C, 8'h00, 8'h00, 8'h00, 8'h00);
    // R5: magic ORed in, then AND
    op(2, 8'h00, 8'hFF, 8'h00, 8'h00, 8'hFF, 8'h00);
    op(2, 8'h11, 8'h0F, 8'h00, 8'h00, 8'h01, 8'h00);
    // R6
    op(3, 8'h01, 8'h00, 8'h00, 8'h00, 8'h9F, 8'h00);
    op(3, 8'h00, 8'h00, 8'h00, 8'h00, 8'h11, 8'h00);
    // R7: SHY/SHX/SHA, including high byte wrap at 0xFF
    op(4, 8'h00, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h12);
    op(5, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h00, 8'hFF);
    op(6, 8'hF7, 8'h7F, 8'h00, 8'h00, 8'h00, 8'h3E);
    // R8
    op(7, 8'hCF, 8'h7E, 8'h00, 8'hFF, 8'h00, 8'h0F);
    // R9
    op(8, 8'h00, 8'h00, 8'h00, 8'hF3, 8'hB6, 8'h00);
    op(8, 8'h00, 8'h00, 8'h00, 8'h0F, 8'hF0, 8'h00);
    // R10: unused codes leave held values
    op(9, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
    op(15, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06);
    // R2: back-to-back starts
    cls_i = 0; opnd_i = 8'h42; start_i = 1'b1;
    @(negedge clk_i);
    cls_i = 1; a_i = 8'hAA; x_i = 8'h0F;
    @(negedge clk_i);
    cls_i = 8; s_i = 8'hFF; opnd_i = 8'h81;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (4) @(negedge clk_i);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule